// File: doc/BRIEF.md
# Special-Register Access Permission Checker

This block judges each move-to or move-from special-register operation before it reaches the register file. It takes the 10-bit register number, the direction, the current privilege state, a lookup result from the implemented-register table, and two control bits from the partitioning control register. It then selects one of four outcomes:
- `V_NORMAL`: the access goes ahead.
- `V_NOOP`: the operation retires and writes nothing.
- `V_TRAP_HV`: a hypervisor emulation-assistance interrupt is raised.
- `V_TRAP_PRV`: a privileged-instruction program interrupt is raised.

A no-op is produced only by withholding the write enables. No register value is written back in its place.

The block is purely combinational and holds no sequential state. There is no clock and no reset. The four outcomes above are the only "states" it can be in. The outcome is a pure function of the inputs in the same cycle, so the usual "transitions" are simply the changes of the outcome from one input pattern to the next.

Alongside the access decision, the block gates the pending external interrupt. The external-interrupt disable control bit is honoured only when the core runs in hypervisor state. Every output is qualified by the instruction-valid input.

Top module: `spr_access_checker`

## Requirements
- R1: While `instr_valid` is 0, every output is 0, whatever the other inputs are.
- R2: In privileged state (`priv_state` = 01), an access to register number 0, 4, 5 or 6 in either direction raises an interrupt with `trap_cause` = 01 (hypervisor emulation assist). This happens even when the lookup reports the register as implemented. Numbers that are equal to these only in their low bits do not trap.
- R3: In privileged state, an access to an undefined register (lookup miss, not 0/4/5/6) raises a `trap_cause` = 01 interrupt when `evirt_en` is 1.
- R4: In privileged state, an access to an undefined register with `evirt_en` = 0 is a no-op: `access_go`, `spr_wr_en`, `gpr_wr_en` and `trap_req` are all 0.
- R5: A normal move-from (`is_write` = 0) asserts `access_go` and `gpr_wr_en` and leaves `spr_wr_en` at 0. A move-from that is a no-op leaves `gpr_wr_en` at 0.
- R6: A normal move-to (`is_write` = 1) asserts `access_go` and `spr_wr_en` and leaves `gpr_wr_en` at 0.
- R7: In problem state (`priv_state` = 00, and 11, which is treated the same way), an access to 0/4/5/6, an undefined register, or a register flagged privileged-only raises an interrupt with `trap_cause` = 10 (privileged program interrupt). Any other implemented register is a normal access.
- R8: In hypervisor state (`priv_state` = 10), an access to 0/4/5/6 or to an undefined register is a no-op regardless of `evirt_en`. An implemented register is a normal access.
- R9: Whenever `trap_req` is 1, both `spr_wr_en` and `gpr_wr_en` are 0. `trap_cause` is non-zero exactly when `trap_req` is 1.
- R10: `ext_irq_take` = `instr_valid` & `ext_irq_pend` & !(`ext_irq_off` & hypervisor state). The disable bit has no effect in problem or privileged state.
- R11: In privileged state, an implemented register is a normal access even when flagged privileged-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_valid | input | 1 | Qualifies all inputs this cycle |
| spr_num | input | 10 | Special-register number |
| is_write | input | 1 | 1 = move-to, 0 = move-from |
| priv_state | input | 2 | 00 problem, 01 privileged, 10 hypervisor, 11 treated as problem |
| spr_known | input | 1 | Lookup hit: the number is implemented |
| spr_priv_only | input | 1 | Lookup: the register needs privilege |
| evirt_en | input | 1 | Undefined numbers trap to the hypervisor in privileged state |
| ext_irq_pend | input | 1 | External interrupt pending |
| ext_irq_off | input | 1 | External-interrupt disable control bit |
| access_go | output | 1 | Access proceeds normally |
| spr_wr_en | output | 1 | Write the special register (move-to) |
| gpr_wr_en | output | 1 | Write the destination general register (move-from) |
| trap_req | output | 1 | Interrupt requested |
| trap_cause | output | 2 | 00 none, 01 hypervisor emulation assist, 10 privileged program |
| ext_irq_take | output | 1 | External interrupt may be taken |

## Verification
The access decision and the external-interrupt gate share the privilege input and can be active in the same cycle. A trap or a no-op must never disturb the interrupt gate, and the interrupt gate must never change the access outcome. The bench provokes this overlap in two ways. It issues hypervisor-state accesses to reserved and undefined numbers while an interrupt is pending with the disable bit set. It also issues privileged-state trapping accesses with the disable bit set. For each cycle, the bench compares every output against a separate reference model of the requirements.

// File: rtl/spr_chk_pkg.sv
package spr_chk_pkg;

    typedef enum logic [1:0] {
        PS_PROBLEM = 2'b00,
        PS_PRIV    = 2'b01,
        PS_HYPER   = 2'b10,
        PS_ALT     = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        V_NORMAL   = 2'd0,
        V_NOOP     = 2'd1,
        V_TRAP_HV  = 2'd2,
        V_TRAP_PRV = 2'd3
    } verdict_e;

    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_HV   = 2'b01;
    localparam logic [1:0] CAUSE_PRV  = 2'b10;

endpackage

// File: rtl/spr_num_class.sv
module spr_num_class #(
    parameter int          NUM_W      = 10,
    parameter int          RSVD_SPAN  = 8,
    parameter logic [7:0]  RSVD_MASK  = 8'b0111_0001
) (
    input  logic [NUM_W-1:0] num,
    input  logic             known,
    input  logic             priv_only,
    output logic             is_rsvd,
    output logic             is_undef,
    output logic             is_privonly
);
    logic [RSVD_SPAN-1:0] hit;

    // One comparator per reserved slot that the mask enables.
    for (genvar i = 0; i < RSVD_SPAN; i++) begin : g_rsvd
        if (RSVD_MASK[i]) begin : g_on
            assign hit[i] = (num == NUM_W'(i));
        end else begin : g_off
            assign hit[i] = 1'b0;
        end
    end

    always_comb begin
        is_rsvd     = |hit;
        is_undef    = !known && !is_rsvd;
        is_privonly = known && priv_only && !is_rsvd;
    end
endmodule

// File: rtl/spr_verdict.sv
module spr_verdict
    import spr_chk_pkg::*;
(
    input  priv_e    priv,
    input  logic     is_rsvd,
    input  logic     is_undef,
    input  logic     is_privonly,
    input  logic     evirt_en,
    output verdict_e verdict
);
    always_comb begin
        verdict = V_NORMAL;
        unique case (priv)
            PS_PRIV: begin
                if (is_rsvd)       verdict = V_TRAP_HV;
                else if (is_undef) verdict = evirt_en ? V_TRAP_HV : V_NOOP;
                else               verdict = V_NORMAL;
            end
            PS_HYPER: begin
                if (is_rsvd || is_undef) verdict = V_NOOP;
                else                     verdict = V_NORMAL;
            end
            PS_PROBLEM, PS_ALT: begin
                if (is_rsvd || is_undef || is_privonly) verdict = V_TRAP_PRV;
                else                                    verdict = V_NORMAL;
            end
        endcase
    end
endmodule

// File: rtl/spr_out_decode.sv
module spr_out_decode
    import spr_chk_pkg::*;
(
    input  verdict_e   verdict,
    input  logic       valid,
    input  logic       is_write,
    output logic       go,
    output logic       spr_we,
    output logic       gpr_we,
    output logic       trap,
    output logic [1:0] cause
);
    always_comb begin
        go     = 1'b0;
        spr_we = 1'b0;
        gpr_we = 1'b0;
        trap   = 1'b0;
        cause  = CAUSE_NONE;
        if (valid) begin
            unique case (verdict)
                V_NORMAL: begin
                    go     = 1'b1;
                    spr_we = is_write;
                    gpr_we = !is_write;
                end
                V_NOOP: begin
                    go = 1'b0;
                end
                V_TRAP_HV: begin
                    trap  = 1'b1;
                    cause = CAUSE_HV;
                end
                V_TRAP_PRV: begin
                    trap  = 1'b1;
                    cause = CAUSE_PRV;
                end
            endcase
        end
    end
endmodule

// File: rtl/ext_irq_gate.sv
module ext_irq_gate
    import spr_chk_pkg::*;
(
    input  logic  valid,
    input  priv_e priv,
    input  logic  pend,
    input  logic  off,
    output logic  take
);
    logic masked;

    always_comb begin
        masked = off && (priv == PS_HYPER);
        take   = valid && pend && !masked;
    end
endmodule

// File: rtl/spr_access_checker.sv
module spr_access_checker
    import spr_chk_pkg::*;
#(
    parameter int         NUM_W     = 10,
    parameter int         RSVD_SPAN = 8,
    parameter logic [7:0] RSVD_MASK = 8'b0111_0001
) (
    input  logic             instr_valid,
    input  logic [NUM_W-1:0] spr_num,
    input  logic             is_write,
    input  logic [1:0]       priv_state,
    input  logic             spr_known,
    input  logic             spr_priv_only,
    input  logic             evirt_en,
    input  logic             ext_irq_pend,
    input  logic             ext_irq_off,
    output logic             access_go,
    output logic             spr_wr_en,
    output logic             gpr_wr_en,
    output logic             trap_req,
    output logic [1:0]       trap_cause,
    output logic             ext_irq_take
);
    priv_e    priv;
    verdict_e verdict;
    logic     c_rsvd, c_undef, c_privonly;

    assign priv = priv_e'(priv_state);

    spr_num_class #(
        .NUM_W(NUM_W), .RSVD_SPAN(RSVD_SPAN), .RSVD_MASK(RSVD_MASK)
    ) u_class (
        .num(spr_num), .known(spr_known), .priv_only(spr_priv_only),
        .is_rsvd(c_rsvd), .is_undef(c_undef), .is_privonly(c_privonly)
    );

    spr_verdict u_verdict (
        .priv(priv), .is_rsvd(c_rsvd), .is_undef(c_undef),
        .is_privonly(c_privonly), .evirt_en(evirt_en), .verdict(verdict)
    );

    spr_out_decode u_out (
        .verdict(verdict), .valid(instr_valid), .is_write(is_write),
        .go(access_go), .spr_we(spr_wr_en), .gpr_we(gpr_wr_en),
        .trap(trap_req), .cause(trap_cause)
    );

    ext_irq_gate u_irq (
        .valid(instr_valid), .priv(priv), .pend(ext_irq_pend),
        .off(ext_irq_off), .take(ext_irq_take)
    );

    always_comb begin
        // R1
        idle_quiet_chk: assert (instr_valid ||
            !(access_go || spr_wr_en || gpr_wr_en || trap_req || ext_irq_take));
        // R9
        trap_excl_chk: assert (!(trap_req && (spr_wr_en || gpr_wr_en)));
        // R9
        cause_match_chk: assert ((trap_cause != CAUSE_NONE) == trap_req);
        // R5
        gpr_dir_chk: assert (!gpr_wr_en || (access_go && !is_write));
        // R6
        spr_dir_chk: assert (!spr_wr_en || (access_go && is_write));
        // R10
        irq_problem_chk: assert (!(instr_valid && ext_irq_pend &&
            priv_state == 2'b00) || ext_irq_take);
        // R2
        rsvd_hv_chk: assert (!(instr_valid && priv_state == 2'b01 && c_rsvd) ||
            (trap_req && trap_cause == CAUSE_HV));
    end
endmodule

// File: tb/sim_spr_access_checker.sv
module sim_spr_access_checker;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       instr_valid, is_write, spr_known, spr_priv_only, evirt_en;
    logic       ext_irq_pend, ext_irq_off;
    logic [9:0] spr_num;
    logic [1:0] priv_state;
    logic       access_go, spr_wr_en, gpr_wr_en, trap_req, ext_irq_take;
    logic [1:0] trap_cause;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    spr_access_checker u0 (
        .instr_valid(instr_valid), .spr_num(spr_num), .is_write(is_write),
        .priv_state(priv_state), .spr_known(spr_known),
        .spr_priv_only(spr_priv_only), .evirt_en(evirt_en),
        .ext_irq_pend(ext_irq_pend), .ext_irq_off(ext_irq_off),
        .access_go(access_go), .spr_wr_en(spr_wr_en), .gpr_wr_en(gpr_wr_en),
        .trap_req(trap_req), .trap_cause(trap_cause), .ext_irq_take(ext_irq_take)
    );

    // Reference model: {go, spr_we, gpr_we, trap, cause[1:0], irq}
    function automatic logic [6:0] model(logic v, logic [9:0] n, logic w,
            logic [1:0] ps, logic kn, logic po, logic ev, logic pend, logic off);
        logic rs, und, irq;
        int   kind; // 0 normal, 1 no-op, 2 hv trap, 3 program trap
        rs  = (n == 10'd0) || (n == 10'd4) || (n == 10'd5) || (n == 10'd6);
        und = !kn && !rs;
        irq = v && pend && !(off && ps == 2'b10);
        if (!v) return 7'b0;
        if (ps == 2'b01)      kind = rs ? 2 : (und ? (ev ? 2 : 1) : 0);
        else if (ps == 2'b10) kind = (rs || und) ? 1 : 0;
        else                  kind = (rs || und || po) ? 3 : 0;
        case (kind)
            0:       return {1'b1, w, !w, 1'b0, 2'b00, irq};
            1:       return {1'b0, 1'b0, 1'b0, 1'b0, 2'b00, irq};
            2:       return {1'b0, 1'b0, 1'b0, 1'b1, 2'b01, irq};
            default: return {1'b0, 1'b0, 1'b0, 1'b1, 2'b10, irq};
        endcase
    endfunction

    task automatic chk(string tag, logic v, logic [9:0] n, logic w, logic [1:0] ps,
            logic kn, logic po, logic ev, logic pend, logic off);
        logic [6:0] got, expv;
        @(negedge clk);
        instr_valid = v; spr_num = n; is_write = w; priv_state = ps;
        spr_known = kn; spr_priv_only = po; evirt_en = ev;
        ext_irq_pend = pend; ext_irq_off = off;
        #1;
        got  = {access_go, spr_wr_en, gpr_wr_en, trap_req, trap_cause, ext_irq_take};
        expv = model(v, n, w, ps, kn, po, ev, pend, off);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: num=%0d ps=%b w=%b got=%b exp=%b",
                     tag, n, ps, w, got, expv);
        end
    endtask

    task automatic t_idle();   // R1
        chk("R1 idle", 0, 10'd0, 1, 2'b01, 0, 0, 1, 1, 0);
        chk("R1 idle", 0, 10'd300, 0, 2'b00, 1, 1, 0, 1, 1);
        chk("R1 idle", 0, 10'd5, 0, 2'b10, 1, 0, 1, 1, 0);
    endtask

    task automatic t_priv_reserved();   // R2
        int nums[4] = '{0, 4, 5, 6};
        foreach (nums[i]) begin
            chk("R2 rsvd trap", 1, 10'(nums[i]), 0, 2'b01, 0, 0, 0, 0, 0);
            chk("R2 rsvd trap", 1, 10'(nums[i]), 1, 2'b01, 1, 0, 1, 0, 0);
        end
        chk("R2 high alias", 1, 10'd516, 0, 2'b01, 1, 0, 0, 0, 0);
        chk("R2 neighbour", 1, 10'd7, 1, 2'b01, 1, 0, 0, 0, 0);
    endtask

    task automatic t_priv_undef();   // R3 R4 R5
        chk("R3 evirt trap", 1, 10'd777, 0, 2'b01, 0, 0, 1, 0, 0);
        chk("R3 evirt trap", 1, 10'd1023, 1, 2'b01, 0, 0, 1, 0, 0);
        chk("R4 noop", 1, 10'd777, 1, 2'b01, 0, 0, 0, 0, 0);
        chk("R5 noop mf", 1, 10'd1023, 0, 2'b01, 0, 0, 0, 0, 0);
    endtask

    task automatic t_normal();   // R5 R6 R11
        chk("R5 move-from", 1, 10'd8, 0, 2'b01, 1, 0, 0, 0, 0);
        chk("R6 move-to", 1, 10'd8, 1, 2'b01, 1, 0, 0, 0, 0);
        chk("R11 privonly ok", 1, 10'd26, 0, 2'b01, 1, 1, 1, 0, 0);
        chk("R11 privonly ok", 1, 10'd26, 1, 2'b01, 1, 1, 0, 0, 0);
    endtask

    task automatic t_problem();   // R7
        chk("R7 privonly trap", 1, 10'd26, 0, 2'b00, 1, 1, 0, 0, 0);
        chk("R7 undef trap", 1, 10'd600, 1, 2'b00, 0, 0, 1, 0, 0);
        chk("R7 rsvd trap", 1, 10'd4, 0, 2'b00, 1, 0, 1, 0, 0);
        chk("R7 user ok", 1, 10'd9, 0, 2'b00, 1, 0, 0, 0, 0);
        chk("R7 alt enc", 1, 10'd26, 1, 2'b11, 1, 1, 0, 0, 0);
        chk("R7 alt user ok", 1, 10'd9, 1, 2'b11, 1, 0, 0, 0, 0);
    endtask

    task automatic t_hyper();   // R8
        chk("R8 rsvd noop", 1, 10'd0, 0, 2'b10, 1, 0, 1, 0, 0);
        chk("R8 undef noop", 1, 10'd700, 1, 2'b10, 0, 0, 1, 0, 0);
        chk("R8 undef noop", 1, 10'd700, 0, 2'b10, 0, 0, 0, 0, 0);
        chk("R8 known ok", 1, 10'd26, 0, 2'b10, 1, 1, 1, 0, 0);
    endtask

    task automatic t_irq_overlap();   // R10 with access in same cycle
        chk("R10 hyp masked", 1, 10'd5, 0, 2'b10, 0, 0, 1, 1, 1);
        chk("R10 hyp open", 1, 10'd5, 0, 2'b10, 0, 0, 1, 1, 0);
        chk("R10 priv ignore off", 1, 10'd6, 1, 2'b01, 0, 0, 0, 1, 1);
        chk("R10 user ignore off", 1, 10'd26, 0, 2'b00, 1, 1, 0, 1, 1);
        chk("R10 no pend", 1, 10'd8, 0, 2'b00, 1, 0, 0, 0, 0);
    endtask

    task automatic t_sweep();   // R9 exhaustive over low numbers
        for (int n = 0; n < 16; n++)
            for (int ps = 0; ps < 4; ps++)
                for (int bits = 0; bits < 64; bits++)
                    chk("R9 sweep", 1, 10'(n), bits[0], 2'(ps), bits[1], bits[2],
                        bits[3], bits[4], bits[5]);
    endtask

    initial begin
        instr_valid = 0; spr_num = '0; is_write = 0; priv_state = '0;
        spr_known = 0; spr_priv_only = 0; evirt_en = 0;
        ext_irq_pend = 0; ext_irq_off = 0;
        repeat (2) @(posedge clk);
        t_idle();
        t_priv_reserved();
        t_priv_undef();
        t_normal();
        t_problem();
        t_hyper();
        t_irq_overlap();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got=expired exp=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule